// File: doc/BRIEF.md
# External Reference Phase-Lock Loop Filter

This block is the digital loop filter of a phase-locked loop. The loop steers a local oscillator onto an external reference clock. A phase detector upstream delivers tagged samples, one at a time. Each sample carries a source channel number and a tag word. The block accepts only samples from the channel selected on `ref_chan`.

From each accepted sample the block rebuilds a continuous phase from a 16-bit phase field and a wrap flag. It takes the difference from the previous continuous phase, which gives a phase error. A clamped proportional-integral controller turns that error into a control word. A fast first-order smoothing filter and a slow one both follow the control word. The fast filter's result is written out as a 16-bit word for the oscillator DAC. The gap between the two filters decides whether the loop counts as locked.

The whole computation for one sample runs between two clock edges. The DAC word, the lock flag and the sample count update on the edge that takes the sample. A `start` pulse brings the loop back to its initial state.

Top module: `extref_loop_filter`

## Requirements
- R1: A sample is accepted only when `smp_valid` is high, `smp_chan` equals `ref_chan` and `start` is low. Any other sample changes no state, so `dac_word`, `locked` and `smp_count` hold and `dac_upd` stays low.
- R2: `smp_tag[15:0]` is the phase and `smp_tag[16]` is the wrap flag. On an accepted sample with the flag set, the running offset loses 65536 if the phase is greater than the previous phase, and gains 65536 otherwise. Without the flag the offset is kept.
- R3: The continuous phase is the phase plus the offset. The error is the current continuous phase minus the previous one. After each accepted sample both the phase and the continuous phase are stored. All arithmetic is signed 32-bit with wraparound.
- R4: The controller computes raw = (((I + e)·KI + e·KP) >>> FRAC) + BIAS, where I is the integrator, e is the error and >>> is an arithmetic shift. Its output is raw clamped to [YMIN, YMAX]. The defaults are KP 300, KI 1, FRAC 12, BIAS 32768, YMIN 5 and YMAX 65531.
- R5: The integrator takes I + e, except when raw > YMAX with e > 0, or when raw < YMIN with e < 0. In those two cases it is left as it is.
- R6: Each smoothing filter updates as s ← s + ((α·(x − s)) >>> 16). The fast filter uses α = 4000 and the slow filter uses α = 1000.
- R7: After reset or `start`, the first accepted sample loads each filter directly with the controller output.
- R8: `dac_word` is the low 16 bits of the fast filter's result. It is registered on the edge that accepts the sample, and `dac_upd` is high for that one cycle. The idle value is 32768.
- R9: While unlocked, `locked` rises on the LOCK_N-th consecutive accepted sample with |fast − slow| < LOCK_THR. Any other accepted sample restarts that count. The defaults are 10000 and 250.
- R10: While locked, `locked` falls on the DELOCK_N-th consecutive accepted sample with |fast − slow| > LOCK_THR. Any other accepted sample restarts that count. The default for DELOCK_N is 9990.
- R11: `start` clears the offset, the stored phases, the integrator, both filters and the lock count, lowers `locked`, zeroes `smp_count` and sets `dac_word` to 32768. A sample presented in the same cycle is dropped.
- R12: `smp_count` increments by one on every accepted sample.
- R13: After reset, `dac_word` is 32768, `locked` is low and `smp_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart pulse that clears the loop state |
| ref_chan | input | CH_W | Channel number of the reference |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | CH_W | Source channel of the sample |
| smp_tag | input | PHASE_W+1 | Wrap flag (top bit) and phase |
| dac_word | output | 16 | Oscillator DAC word |
| dac_upd | output | 1 | Pulses when the DAC word is refreshed |
| locked | output | 1 | Lock indication |
| smp_count | output | 32 | Accepted samples since start |

## Verification
The bench uses steep controller gains, so that the clamp and the integrator rule can be seen in single samples. It checks two hand-worked cases. In the first, a large first error pins the DAC word at a rail. In the second, a zero-error sample that follows it gives one value when the integrator was frozen and a different one when it was not. A run of zero-error samples shows the exact sample on which lock rises. A ramp that follows it shows the delock count.

Two phase sawtooths are applied, one rising and one falling, with the wrap flag set on each crossing. They exercise both directions of the offset correction. A long pseudo-random run mixes foreign channels with arbitrary phases and flags. It is compared sample by sample with an arithmetic model, which separates the ignore rule, the wrap rule and the 32-bit wraparound of the integrator.

// File: rtl/extref_pkg.sv
// Package: shared types and constants for the external reference loop filter.
// Assumes every datapath quantity is a signed 32-bit word with wraparound.
package extref_pkg;
    typedef logic signed [31:0] word_t;
    localparam int SMOOTH_SH = 16;   // fixed-point shift of the smoothing gain
    localparam int DAC_W     = 16;   // width of the oscillator DAC word
endpackage

// File: rtl/extref_unwrap.sv
// Module: rebuilds a continuous phase from a short phase field plus a wrap
// flag, and gives the difference from the previous continuous phase.
// Assumes acc and clr never need to act together (clr wins).
module extref_unwrap
    import extref_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               acc,
    input  logic [PHASE_W-1:0] phase,
    input  logic               wrap,
    output word_t              err
);
    localparam word_t STEP = word_t'(1) << PHASE_W;

    word_t              off_q, unw_q, off_n, unw_n;
    logic [PHASE_W-1:0] raw_q;

    // Offset correction on a flagged wrap and the error of this sample.
    always_comb begin
        off_n = off_q;
        if (wrap) off_n = (phase > raw_q) ? off_q - STEP : off_q + STEP;
        unw_n = word_t'({{(32-PHASE_W){1'b0}}, phase}) + off_n;
        err   = unw_n - unw_q;
    end

    // Phase history: cleared by reset or clr, advanced on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            off_q <= '0;
            unw_q <= '0;
            raw_q <= '0;
        end else if (acc) begin
            off_q <= off_n;
            unw_q <= unw_n;
            raw_q <= phase;
        end
    end

    // R2
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr && !wrap) |=> $stable(off_q));
endmodule

// File: rtl/extref_pi.sv
// Module: clamped proportional-integral controller with anti-windup.
// Assumes products wrap at 32 bits and FRAC is below 32.
module extref_pi
    import extref_pkg::*;
#(
    parameter int KP   = 300,
    parameter int KI   = 1,
    parameter int FRAC = 12,
    parameter int BIAS = 32768,
    parameter int YMIN = 5,
    parameter int YMAX = 65531
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  acc,
    input  word_t err,
    output word_t y
);
    localparam word_t KP_S = word_t'(KP);
    localparam word_t KI_S = word_t'(KI);
    localparam word_t BI_S = word_t'(BIAS);
    localparam word_t LO_S = word_t'(YMIN);
    localparam word_t HI_S = word_t'(YMAX);

    word_t integ_q, sum, raw;
    logic  sat_hi, sat_lo;

    // Raw controller output and clamp.
    always_comb begin
        sum    = integ_q + err;
        raw    = ((sum * KI_S) + (err * KP_S)) >>> FRAC;
        raw    = raw + BI_S;
        sat_hi = raw > HI_S;
        sat_lo = raw < LO_S;
        y      = sat_hi ? HI_S : (sat_lo ? LO_S : raw);
    end

    // Integrator, frozen while pushing further into a saturated rail.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            integ_q <= '0;
        end else if (acc && !((sat_hi && err > 0) || (sat_lo && err < 0))) begin
            integ_q <= sum;
        end
    end

    // R5
    antiwindup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr && sat_hi && err > 0) |=> $stable(integ_q));
endmodule

// File: rtl/extref_smooth.sv
// Module: first-order smoothing filter. The first sample after a clear loads
// the state directly; later samples move it by alpha/65536 of the gap.
// Assumes alpha times the largest input gap fits in 32 bits.
module extref_smooth
    import extref_pkg::*;
#(
    parameter int ALPHA = 4000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  acc,
    input  word_t x,
    output word_t y_next
);
    localparam word_t A_S = word_t'(ALPHA);

    word_t st_q, prod;
    logic  init_q;

    // Value the filter takes on this sample.
    always_comb begin
        prod   = A_S * (x - st_q);
        y_next = init_q ? st_q + (prod >>> SMOOTH_SH) : x;
    end

    // State register and its loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q   <= '0;
            init_q <= 1'b0;
        end else if (acc) begin
            st_q   <= y_next;
            init_q <= 1'b1;
        end
    end

    // R7
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr && !init_q) |=> (st_q == $past(x)));
endmodule

// File: rtl/extref_lockdet.sv
// Module: lock judge with a consecutive-sample count to enter lock and a
// second count to leave it. Assumes LOCK_N and DELOCK_N are at least 1.
module extref_lockdet
    import extref_pkg::*;
#(
    parameter int THR      = 250,
    parameter int LOCK_N   = 10000,
    parameter int DELOCK_N = 9990
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  acc,
    input  word_t gap,
    output logic  locked
);
    localparam int             CNT_MAX = (LOCK_N > DELOCK_N) ? LOCK_N : DELOCK_N;
    localparam int             CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]  IN_LAST = CW'(LOCK_N - 1);
    localparam logic [CW-1:0]  OUT_LAST = CW'(DELOCK_N - 1);
    localparam word_t          THR_S   = word_t'(THR);

    word_t         mag;
    logic          below, above;
    logic [CW-1:0] cnt_q;

    // Size of the gap against the threshold.
    always_comb begin
        mag   = (gap < 0) ? -gap : gap;
        below = mag < THR_S;
        above = mag > THR_S;
    end

    // Consecutive-sample counting and lock state changes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (acc) begin
            if (!locked) begin
                if (!below)                cnt_q <= '0;
                else if (cnt_q == IN_LAST) begin cnt_q <= '0; locked <= 1'b1; end
                else                       cnt_q <= cnt_q + 1'b1;
            end else begin
                if (!above)                 cnt_q <= '0;
                else if (cnt_q == OUT_LAST) begin cnt_q <= '0; locked <= 1'b0; end
                else                        cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(acc && !clr));
    // R10
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(acc || clr));
endmodule

// File: rtl/extref_loop_filter.sv
// Module: top of the external reference loop filter. It selects reference
// samples, chains unwrap, controller, two smoothing filters and the lock
// judge, and registers the DAC word and sample count.
// Assumes one sample at most per cycle; start takes priority over a sample.
module extref_loop_filter
    import extref_pkg::*;
#(
    parameter int CH_W        = 3,
    parameter int PHASE_W     = 16,
    parameter int KP          = 300,
    parameter int KI          = 1,
    parameter int FRAC        = 12,
    parameter int BIAS        = 32768,
    parameter int YMIN        = 5,
    parameter int YMAX        = 65531,
    parameter int ALPHA_SHORT = 4000,
    parameter int ALPHA_LONG  = 1000,
    parameter int LOCK_THR    = 250,
    parameter int LOCK_N      = 10000,
    parameter int DELOCK_N    = 9990
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CH_W-1:0]    ref_chan,
    input  logic               smp_valid,
    input  logic [CH_W-1:0]    smp_chan,
    input  logic [PHASE_W:0]   smp_tag,
    output logic [DAC_W-1:0]   dac_word,
    output logic               dac_upd,
    output logic               locked,
    output logic [31:0]        smp_count
);
    localparam int              NFILT    = 2;
    localparam logic [DAC_W-1:0] DAC_IDLE = DAC_W'(BIAS);
    localparam logic [DAC_W-1:0] DAC_LO   = DAC_W'(YMIN);
    localparam logic [DAC_W-1:0] DAC_HI   = DAC_W'(YMAX);

    logic  acc;
    word_t err, ctrl;
    word_t filt [NFILT];

    // Reference sample selection.
    always_comb acc = smp_valid && (smp_chan == ref_chan) && !start;

    extref_unwrap #(.PHASE_W(PHASE_W)) unwrap_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .acc(acc),
        .phase(smp_tag[PHASE_W-1:0]), .wrap(smp_tag[PHASE_W]), .err(err)
    );

    extref_pi #(
        .KP(KP), .KI(KI), .FRAC(FRAC), .BIAS(BIAS), .YMIN(YMIN), .YMAX(YMAX)
    ) pi_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .acc(acc), .err(err), .y(ctrl)
    );

    // Fast filter at index 0, slow filter at index 1.
    for (genvar g = 0; g < NFILT; g++) begin : g_filt
        extref_smooth #(.ALPHA((g == 0) ? ALPHA_SHORT : ALPHA_LONG)) smooth_i (
            .clk(clk), .rst_n(rst_n), .clr(start), .acc(acc),
            .x(ctrl), .y_next(filt[g])
        );
    end

    extref_lockdet #(.THR(LOCK_THR), .LOCK_N(LOCK_N), .DELOCK_N(DELOCK_N)) lock_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .acc(acc),
        .gap(filt[0] - filt[1]), .locked(locked)
    );

    // Output registers: DAC word, refresh pulse and sample count.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            dac_word  <= DAC_IDLE;
            dac_upd   <= 1'b0;
            smp_count <= '0;
        end else begin
            dac_upd <= acc;
            if (acc) begin
                dac_word  <= filt[0][DAC_W-1:0];
                smp_count <= smp_count + 32'd1;
            end
        end
    end

    // R1
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan != ref_chan && !start)
        |=> ($stable(smp_count) && $stable(dac_word) && !dac_upd));
    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (smp_count == 32'd0 && !locked && dac_word == DAC_IDLE));
    // R12
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (smp_count == $past(smp_count) + 32'd1));
    // R4
    dac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |-> (dac_word >= DAC_LO && dac_word <= DAC_HI));
endmodule

// File: tb/extref_loop_filter_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus sawtooth and pseudo-random sweeps,
// compared against an arithmetic model of the requirements.
module extref_loop_filter_tb_top;
    localparam int KP = 8192, KI = 4096, FRAC = 12;
    localparam int BIAS = 32768, YMIN = 5, YMAX = 65531;
    localparam int AS = 4000, AL = 1000, THR = 250, LN = 8, DN = 6;
    localparam logic [2:0] REF = 3'd3;

    logic        clk = 0, rst_n = 0, start = 0, smp_valid = 0;
    logic [2:0]  smp_chan = '0;
    logic [16:0] smp_tag = '0;
    logic [15:0] dac_word;
    logic        dac_upd, locked;
    logic [31:0] smp_count;

    int nvec = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    extref_loop_filter #(
        .CH_W(3), .PHASE_W(16), .KP(KP), .KI(KI), .FRAC(FRAC), .BIAS(BIAS),
        .YMIN(YMIN), .YMAX(YMAX), .ALPHA_SHORT(AS), .ALPHA_LONG(AL),
        .LOCK_THR(THR), .LOCK_N(LN), .DELOCK_N(DN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_chan(REF),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_tag(smp_tag),
        .dac_word(dac_word), .dac_upd(dac_upd), .locked(locked),
        .smp_count(smp_count)
    );

    // Model state
    int m_off, m_raw, m_unw, m_int, m_fs, m_fl, m_cnt, m_lcnt, m_dac;
    bit m_fsi, m_fli, m_lock;

    task automatic chk(string req, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_clear();
        m_off = 0; m_raw = 0; m_unw = 0; m_int = 0; m_fs = 0; m_fl = 0;
        m_cnt = 0; m_lcnt = 0; m_dac = BIAS; m_fsi = 0; m_fli = 0; m_lock = 0;
    endtask

    task automatic m_step(int ph, bit wr);
        int u, e, raw, y, g, mag;
        if (wr) m_off = (ph > m_raw) ? m_off - 65536 : m_off + 65536;
        m_raw = ph;
        u = ph + m_off;
        e = u - m_unw;
        m_unw = u;
        raw = (((m_int + e) * KI) + (e * KP)) >>> FRAC;
        raw = raw + BIAS;
        y = (raw > YMAX) ? YMAX : ((raw < YMIN) ? YMIN : raw);
        if (!((raw > YMAX && e > 0) || (raw < YMIN && e < 0))) m_int = m_int + e;
        if (!m_fsi) begin m_fs = y; m_fsi = 1; end
        else m_fs = m_fs + ((AS * (y - m_fs)) >>> 16);
        if (!m_fli) begin m_fl = y; m_fli = 1; end
        else m_fl = m_fl + ((AL * (y - m_fl)) >>> 16);
        g = m_fs - m_fl;
        mag = (g < 0) ? -g : g;
        if (!m_lock) begin
            if (!(mag < THR)) m_lcnt = 0;
            else if (m_lcnt == LN - 1) begin m_lcnt = 0; m_lock = 1; end
            else m_lcnt++;
        end else begin
            if (!(mag > THR)) m_lcnt = 0;
            else if (m_lcnt == DN - 1) begin m_lcnt = 0; m_lock = 0; end
            else m_lcnt++;
        end
        m_dac = m_fs & 32'hFFFF;
        m_cnt++;
    endtask

    // One sample; outputs compared after the capturing edge.
    task automatic send(logic [2:0] ch, int ph, bit wr, string req);
        @(negedge clk);
        smp_valid = 1; smp_chan = ch; smp_tag = {wr, ph[15:0]};
        @(negedge clk);
        smp_valid = 0;
        if (ch == REF) m_step(ph & 32'hFFFF, wr);
        chk(req, "dac_word", int'(dac_word), m_dac);
        chk(req, "locked", int'(locked), int'(m_lock));
        chk("R12", "smp_count", int'(smp_count), m_cnt);
        chk("R8", "dac_upd", int'(dac_upd), (ch == REF) ? 1 : 0);
    endtask

    task automatic restart();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        m_clear();
        chk("R11", "count after start", int'(smp_count), 0);
        chk("R11", "lock after start", int'(locked), 0);
        chk("R11", "dac after start", int'(dac_word), BIAS);
    endtask

    initial begin
        int unsigned seed;
        int ph;
        m_clear();
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "dac_word", int'(dac_word), BIAS);
        chk("R13", "locked", int'(locked), 0);
        chk("R13", "smp_count", int'(smp_count), 0);
        rst_n = 1;

        // R4 upper clamp, R7 first sample loads the filter
        restart();
        send(REF, 20000, 0, "R4");
        chk("R7", "first sample loads rail", int'(dac_word), 65531);
        // R5 anti-windup: frozen integrator gives 63531, not 64752
        send(REF, 20000, 0, "R5");
        chk("R5", "integrator frozen", int'(dac_word), 63531);

        // R4 lower clamp through a flagged wrap (R2): error -20000
        restart();
        send(REF, 45536, 1, "R2");
        chk("R4", "lower rail", int'(dac_word), 5);

        // R9 lock after exactly LN zero-error samples
        restart();
        for (int i = 0; i < LN - 1; i++) send(REF, 0, 0, "R9");
        chk("R9", "not yet locked", int'(locked), 0);
        send(REF, 0, 0, "R9");
        chk("R9", "locked at count", int'(locked), 1);
        // R10 ramp separates the filters; lock drops only after DN samples
        ph = 0;
        for (int i = 0; i < 2; i++) begin ph += 200; send(REF, ph, 0, "R10"); end
        chk("R10", "still locked early", int'(locked), 1);
        for (int i = 0; i < 18; i++) begin ph += 200; send(REF, ph, 0, "R10"); end
        chk("R10", "unlocked after ramp", int'(locked), 0);

        // R1 foreign channel leaves everything untouched
        send(3'd5, 1234, 1, "R1");
        send(3'd0, 60000, 0, "R1");
        send(REF, ph, 0, "R1");

        // R11 start and sample in the same cycle: sample dropped
        @(negedge clk);
        start = 1; smp_valid = 1; smp_chan = REF; smp_tag = 17'd999;
        @(negedge clk);
        start = 0; smp_valid = 0;
        m_clear();
        chk("R11", "count with start", int'(smp_count), 0);
        chk("R11", "dac with start", int'(dac_word), BIAS);
        send(REF, 500, 0, "R11");

        // R2/R3 rising sawtooth, flag set on each crossing
        restart();
        ph = 0;
        for (int i = 0; i < 60; i++) begin
            int nx;
            nx = ph + 7000;
            send(REF, nx % 65536, (nx >= 65536) ? 1'b1 : 1'b0, "R3");
            ph = nx % 65536;
        end
        // R2/R3 falling sawtooth
        for (int i = 0; i < 60; i++) begin
            int nx;
            nx = ph - 5000;
            send(REF, (nx < 0) ? nx + 65536 : nx, (nx < 0) ? 1'b1 : 1'b0, "R2");
            ph = (nx < 0) ? nx + 65536 : nx;
        end

        // R6 pseudo-random mix of channels, phases and flags
        restart();
        seed = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ch;
            seed = seed * 32'd1103515245 + 32'd12345;
            ch = seed[4] ? REF : seed[7:5];
            send(ch, int'(seed[31:16]), seed[9] & seed[10], "R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        done = 1;
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule